// File: doc/BRIEF.md
# Cell-Synchronous Link Alignment Controller

This block sits on one serial-link port of a cell-switched fabric. It lines up fixed-length cell traffic with the master cell clock kept by a central switch. The block runs in cell mode only when both `bypass_en` and `cellsync_en` are high. In every other case it passes words through without alignment. In cell mode it watches a per-cell reference marker and locks onto it. The block then has a local cell phase. It derives from that phase a transmit cell strobe, moved earlier by a programmable advance, so that the first word of a cell reaches the switch exactly on the switch's boundary.

The transmit path is a combinational valid/ready stream. A word flagged as start-of-cell is held back until the strobe fires: both `tx_out_valid` and `tx_in_ready` stay low until then. Words in the middle of a cell are forwarded whenever the sink is ready. The sink applies back-pressure through `tx_out_ready`. The receive path has no ready signal, because a serial link cannot be stalled. Each received word appears on the output a fixed number of clocks after it arrives.

There are two link modes:
- **Multi-link mode** (`single_link` low): the reference marker comes from `ext_cell_ref`. Received words are delayed by a programmable number of word clocks, so that parallel links deliver their cells on a shared boundary.
- **Single-link mode** (`single_link` high): the reference is taken from the start-of-cell words embedded in the received stream. The receive delay is skipped, and the recovered cell clock is driven out for slave links to use.

Both the transmit advance and the receive delay are set by command words. A command takes effect only at a cell boundary.

Top module: `cell_align_ctrl`

## Requirements
- R1: When `bypass_en` and `cellsync_en` are not both high, received words leave the block exactly 1 clock after they arrive. Start-of-cell words pass on the transmit path without waiting. `tx_cell_strobe`, `rec_cell_out` and `cell_locked` stay 0.
- R2: In cell mode, `cell_locked` rises in the clock after the third consecutive reference marker, where consecutive markers are exactly CELL_LEN clocks apart. The marker is `ext_cell_ref` in multi-link mode, and `rx_in_valid && rx_in_soc` in single-link mode.
- R3: A marker that arrives at any spacing other than CELL_LEN clears `cell_locked` in the next clock. A marker that is missing at its expected slot does the same. Acquisition then restarts, and an off-period marker counts as the first marker of a new run.
- R4: In single-link mode, while the block is locked, `rec_cell_out` pulses for one clock, in the clock after each marker. In multi-link mode it stays 0.
- R5: While the block is locked, `tx_cell_strobe` pulses once per cell, (advance mod CELL_LEN) clocks before the local boundary. The local boundary is the clock after a marker. With advance 3 and CELL_LEN 16, the strobe falls 14 clocks after a marker.
- R6: In cell mode, a transmit word with `tx_in_soc`=1 is offered (`tx_out_valid`) and accepted (`tx_in_ready`) only in a clock where `tx_cell_strobe` is 1. A word with `tx_in_soc`=0 passes whenever `tx_out_ready` is 1.
- R7: In multi-link mode, a received word appears on the receive output 1 + D clocks after it arrives, where D (0 to 31) is the active receive delay.
- R8: In single-link mode, the receive delay is ignored and the receive latency is exactly 1 clock.
- R9: A command (`cmd_valid`=1; `cmd_sel`=0 writes the advance, `cmd_sel`=1 writes the receive delay, with the value on `cmd_value`) takes effect in cell mode only at the edge that ends phase CELL_LEN-1. A word that arrives before that edge still sees the old value. Outside cell mode, a command takes effect at the next edge.
- R10: After reset the advance and the receive delay are both 0, `cell_locked` is 0, and no receive word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Disables the routing path; one of the two cell-mode enables |
| cellsync_en | input | 1 | Cell synchronisation enable; one of the two cell-mode enables |
| single_link | input | 1 | 1 = single-link mode, 0 = multi-link mode |
| ext_cell_ref | input | 1 | Reference cell marker used in multi-link mode |
| cmd_valid | input | 1 | Command word strobe |
| cmd_sel | input | 1 | 0 = transmit advance, 1 = receive delay |
| cmd_value | input | DLY_W | New advance or delay value |
| tx_in_valid | input | 1 | Transmit source word valid |
| tx_in_ready | output | 1 | Transmit source word accepted |
| tx_in_data | input | DATA_W | Transmit source word |
| tx_in_soc | input | 1 | Transmit word is the first word of a cell |
| tx_out_valid | output | 1 | Transmit word offered to the link |
| tx_out_ready | input | 1 | Link side ready |
| tx_out_data | output | DATA_W | Transmit word to the link |
| tx_out_soc | output | 1 | Start-of-cell flag to the link |
| rx_in_valid | input | 1 | Received word valid |
| rx_in_data | input | DATA_W | Received word |
| rx_in_soc | input | 1 | Received start-of-cell / embedded marker |
| rx_out_valid | output | 1 | Aligned receive word valid |
| rx_out_data | output | DATA_W | Aligned receive word |
| rx_out_soc | output | 1 | Aligned start-of-cell flag |
| tx_cell_strobe | output | 1 | Advanced transmit cell strobe |
| rec_cell_out | output | 1 | Recovered cell clock for slave links |
| cell_locked | output | 1 | Reference lock flag |

## Verification
The assertions check several rules on every clock:
- a lock can only rise after a marker;
- an off-period marker always clears the lock;
- the recovered clock pulses only after a marker;
- a start-of-cell transmit word is offered only on the strobe;
- the active delays change only at an update point;
- the single-link receive latency is one clock.

Only the bench scenarios can show the following:
- the exact clock in which lock is acquired and lost;
- where the strobe falls for a given advance;
- the receive delay before and after a command lands at a boundary;
- the difference in behaviour between non-cell, multi-link and single-link operation.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic {
    CMD_TX_ADV = 1'b0,
    CMD_RX_DLY = 1'b1
  } cmd_sel_e;

  // Phase at which the advanced transmit strobe fires.
  function automatic int strobe_phase(input int adv, input int len);
    int m;
    m = adv % len;
    return (m == 0) ? 0 : (len - m);
  endfunction

endpackage

// File: rtl/cal_cell_lock.sv
module cal_cell_lock #(
  parameter int CELL_LEN = 16,
  parameter int PH_W     = $clog2(CELL_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            mark,
  output logic [PH_W-1:0] phase,
  output logic            locked,
  output logic            boundary
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CELL_LEN - 1);

  logic [1:0] run_cnt;
  logic       at_last;

  assign at_last  = (phase == LAST);
  assign boundary = enable && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      phase   <= '0;
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (mark) begin
      phase <= '0;
      if (at_last) begin
        if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
        locked <= (run_cnt >= 2'd2);
      end else begin
        run_cnt <= 2'd1;
        locked  <= 1'b0;
      end
    end else if (at_last) begin
      phase   <= '0;
      run_cnt <= '0;
      locked  <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assert_lock_after_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(mark) && $past(enable)));

  assert_offperiod_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mark && !at_last) |=> !locked);

endmodule

// File: rtl/cal_cmd_regs.sv
module cal_cmd_regs #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic             cmd_valid,
  input  logic             cmd_sel,
  input  logic [DLY_W-1:0] cmd_value,
  output logic [DLY_W-1:0] tx_adv,
  output logic [DLY_W-1:0] rx_dly
);
  import cal_pkg::*;

  logic [DLY_W-1:0] pend_tx, pend_rx, next_tx, next_rx;
  logic             wr_tx, wr_rx;

  assign wr_tx   = cmd_valid && (cmd_sel_e'(cmd_sel) == CMD_TX_ADV);
  assign wr_rx   = cmd_valid && (cmd_sel_e'(cmd_sel) == CMD_RX_DLY);
  assign next_tx = wr_tx ? cmd_value : pend_tx;
  assign next_rx = wr_rx ? cmd_value : pend_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_tx <= '0;
      pend_rx <= '0;
      tx_adv  <= '0;
      rx_dly  <= '0;
    end else begin
      pend_tx <= next_tx;
      pend_rx <= next_rx;
      if (apply) begin
        tx_adv <= next_tx;
        rx_dly <= next_rx;
      end
    end
  end

  assert_update_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> ($stable(tx_adv) && $stable(rx_dly)));

endmodule

// File: rtl/cal_rx_delay.sv
module cal_rx_delay #(
  parameter int DATA_W = 16,
  parameter int DLY_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  sel,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_soc,
  output logic [DATA_W-1:0] out_data
);
  localparam int DEPTH = 1 << DLY_W;
  localparam int W     = DATA_W + 2;

  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= {in_valid, in_soc, in_data};
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign {out_valid, out_soc, out_data} = stage[sel];

endmodule

// File: rtl/cell_align_ctrl.sv
module cell_align_ctrl #(
  parameter int CELL_LEN = 16,
  parameter int DATA_W   = 16,
  parameter int DLY_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass_en,
  input  logic              cellsync_en,
  input  logic              single_link,
  input  logic              ext_cell_ref,
  input  logic              cmd_valid,
  input  logic              cmd_sel,
  input  logic [DLY_W-1:0]  cmd_value,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  input  logic              tx_in_soc,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_out_soc,
  input  logic              rx_in_valid,
  input  logic [DATA_W-1:0] rx_in_data,
  input  logic              rx_in_soc,
  output logic              rx_out_valid,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_soc,
  output logic              tx_cell_strobe,
  output logic              rec_cell_out,
  output logic              cell_locked
);
  import cal_pkg::*;

  localparam int PH_W = $clog2(CELL_LEN);

  logic             cell_mode, mark_src, boundary, tx_gate;
  logic [PH_W-1:0]  phase, tx_slot;
  logic [DLY_W-1:0] tx_adv, rx_dly, rx_sel;

  assign cell_mode = bypass_en && cellsync_en;
  assign mark_src  = single_link ? (rx_in_valid && rx_in_soc) : ext_cell_ref;

  cal_cell_lock #(.CELL_LEN(CELL_LEN), .PH_W(PH_W)) lock_i (
    .clk(clk), .rst_n(rst_n), .enable(cell_mode), .mark(mark_src),
    .phase(phase), .locked(cell_locked), .boundary(boundary)
  );

  cal_cmd_regs #(.DLY_W(DLY_W)) cmd_i (
    .clk(clk), .rst_n(rst_n), .apply(boundary || !cell_mode),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_value(cmd_value),
    .tx_adv(tx_adv), .rx_dly(rx_dly)
  );

  // Receive: delay only in multi-link cell mode.
  assign rx_sel = (cell_mode && !single_link) ? rx_dly : '0;

  cal_rx_delay #(.DATA_W(DATA_W), .DLY_W(DLY_W)) rxd_i (
    .clk(clk), .rst_n(rst_n), .sel(rx_sel),
    .in_valid(rx_in_valid), .in_soc(rx_in_soc), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_soc(rx_out_soc), .out_data(rx_out_data)
  );

  // Transmit strobe advanced ahead of the local boundary.
  always_comb tx_slot = PH_W'(strobe_phase(int'(tx_adv), CELL_LEN));

  assign tx_cell_strobe = cell_locked && (phase == tx_slot);
  assign rec_cell_out   = single_link && cell_locked && (phase == '0);

  // Start-of-cell words wait for the strobe; valid/ready pass otherwise.
  assign tx_gate      = !cell_mode || !tx_in_soc || tx_cell_strobe;
  assign tx_out_valid = tx_in_valid && tx_gate;
  assign tx_in_ready  = tx_out_ready && tx_gate;
  assign tx_out_data  = tx_in_data;
  assign tx_out_soc   = tx_in_soc;

  assert_soc_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_mode && tx_out_valid && tx_out_soc) |-> tx_cell_strobe);

  assert_rec_after_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_cell_out |-> $past(mark_src));

  assert_single_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_mode && single_link) |=>
      (!(cell_mode && single_link) || (rx_out_valid == $past(rx_in_valid))));

  assert_no_lock_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_mode |=> !cell_locked);

endmodule

// File: tb/cell_align_ctrl_tb_top.sv
module cell_align_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_en = 0, cellsync_en = 0, single_link = 0, ext_cell_ref = 0;
  logic cmd_valid = 0, cmd_sel = 0;
  logic [4:0] cmd_value = '0;
  logic tx_in_valid = 0, tx_in_soc = 0, tx_out_ready = 0;
  logic [15:0] tx_in_data = '0;
  logic rx_in_valid = 0, rx_in_soc = 0;
  logic [15:0] rx_in_data = '0;
  logic tx_in_ready, tx_out_valid, tx_out_soc, rx_out_valid, rx_out_soc;
  logic [15:0] tx_out_data, rx_out_data;
  logic tx_cell_strobe, rec_cell_out, cell_locked;

  int cyc = 0, total = 0, bad = 0;

  typedef struct { logic [15:0] d; logic s; int due; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cell_align_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Monitor: pops expected receive words and compares data and arrival cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due < cyc) begin
      chk(0, "R7 rx word missing", cyc, sb[0].due);
      void'(sb.pop_front());
    end
    if (rst_n && rx_out_valid) begin
      if (sb.size() == 0) chk(0, "R7 unexpected rx word", rx_out_data, -1);
      else begin
        chk(rx_out_data == sb[0].d && rx_out_soc == sb[0].s, "R7 rx data", rx_out_data, sb[0].d);
        chk(cyc == sb[0].due, "R7/R8 rx latency", cyc, sb[0].due);
        void'(sb.pop_front());
      end
    end
  end

  // Driver: one clock of stimulus; pushes the expected receive word.
  task automatic drive(input bit mark, input bit rv, input bit rs, input logic [15:0] rd, input int lat);
    @(negedge clk);
    ext_cell_ref = mark; rx_in_valid = rv; rx_in_soc = rs; rx_in_data = rd;
    cmd_valid = 0;
    if (rv) sb.push_back('{rd, rs, cyc + 1 + lat});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 16'h0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cell_locked == 0, "R10 lock after reset", cell_locked, 0);
    chk(rx_out_valid == 0, "R10 rx idle after reset", rx_out_valid, 0);
    chk(tx_cell_strobe == 0, "R10 strobe after reset", tx_cell_strobe, 0);

    // ---- R1: not cell mode (cellsync low)
    bypass_en = 1; cellsync_en = 0;
    tx_in_valid = 1; tx_in_soc = 1; tx_out_ready = 1; tx_in_data = 16'h55;
    drive(0, 1, 0, 16'h0011, 0);
    chk(tx_out_valid == 1 && tx_in_ready == 1, "R1 soc passes", tx_out_valid, 1);
    for (int k = 0; k < 50; k++) begin
      drive(k % 16 == 0, 0, 0, 16'h0, 0);
      if (cell_locked || tx_cell_strobe || rec_cell_out) chk(0, "R1 no lock outside cell mode", cell_locked, 0);
    end
    chk(cell_locked == 0, "R1 lock stays low", cell_locked, 0);
    tx_in_valid = 0; tx_in_soc = 0;

    // ---- multi-link cell mode
    cellsync_en = 1; single_link = 0;
    drive(0, 1, 1, 16'h0022, 0);            // R10: delay resets to 0
    idle(3);
    @(negedge clk); cmd_valid = 1; cmd_sel = 0; cmd_value = 5'd3;
    @(negedge clk); cmd_valid = 1; cmd_sel = 1; cmd_value = 5'd5;
    idle(20);
    for (int k = 0; k < 96; k++) begin
      bit m;
      m = (k % 16 == 0) || (k == 90);
      if (k == 20 || k == 40 || k == 67) drive(m, 1, 0, 16'h1000 + 16'(k), 5);   // R7 delay 5
      else if (k == 82) drive(m, 1, 0, 16'h1000 + 16'(k), 9);                  // R9 new delay
      else drive(m, 0, 0, 16'h0, 0);
      if (k == 66) begin cmd_valid = 1; cmd_sel = 1; cmd_value = 5'd9; end
      if (k == 50) begin tx_in_valid = 1; tx_in_soc = 1; tx_in_data = 16'hC0; end
      if (k == 32) chk(cell_locked == 0, "R2 not locked before 3rd", cell_locked, 0);
      if (k == 33) chk(cell_locked == 1, "R2 locked after 3rd marker", cell_locked, 1);
      if (k == 61) chk(tx_cell_strobe == 0, "R5 strobe early", tx_cell_strobe, 0);
      if (k == 62) chk(tx_cell_strobe == 1, "R5 strobe at advance 3", tx_cell_strobe, 1);
      if (k == 55) chk(tx_out_valid == 0 && tx_in_ready == 0, "R6 soc held", tx_out_valid, 0);
      if (k == 62) chk(tx_out_valid == 1 && tx_in_ready == 1, "R6 soc on strobe", tx_out_valid, 1);
      if (k == 63) begin
        tx_in_soc = 0;
        #1 chk(tx_out_valid == 1, "R6 mid-cell word passes", tx_out_valid, 1);
      end
      if (k == 64) tx_in_valid = 0;
      if (k == 65) chk(rec_cell_out == 0, "R4 no rec clock in multi", rec_cell_out, 0);
      if (k == 90) chk(cell_locked == 1, "R3 locked before off marker", cell_locked, 1);
      if (k == 91) chk(cell_locked == 0, "R3 off-period clears lock", cell_locked, 0);
    end
    idle(40);

    // ---- single-link cell mode
    single_link = 1;
    for (int k = 0; k < 92; k++) begin
      drive(0, 1, (k % 16 == 0) && (k <= 64), 16'h2000 + 16'(k), 0);   // R8 delay 9 ignored
      if (k == 33) chk(cell_locked == 1, "R2 single-link lock", cell_locked, 1);
      if (k == 49) chk(rec_cell_out == 1, "R4 rec clock after marker", rec_cell_out, 1);
      if (k == 50) chk(rec_cell_out == 0, "R4 rec clock one cycle", rec_cell_out, 0);
      if (k == 80) chk(cell_locked == 1, "R3 locked before missing marker", cell_locked, 1);
      if (k == 81) chk(cell_locked == 0, "R3 missing marker clears lock", cell_locked, 0);
    end
    idle(40);
    chk(sb.size() == 0, "R7 scoreboard drained", sb.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule